// File: doc/BRIEF.md
# Oscillator Control Unit with Suspend and Wake

This block manages an on-chip oscillator from a small register interface. Software programs an 8-bit control word that enables the oscillator, requests suspend and picks a divide ratio, and it reads back a ready flag. A separate calibration register holds the trim code sent to the analog oscillator. The analog oscillator itself is modelled as an input tick in the block's clock domain. The block counts those ticks to time a settling interval, and it divides them by 1, 2, 4 or 8 to produce a one-cycle system clock enable.

A suspend request stops the oscillator. It stays stopped until a wake event arrives, either from a supply-detect interrupt or from USB resume signalling while the USB transceiver is active. The block also reports whether the oscillator still qualifies as a USB clock source. It loses that status for good, until the next reset, once software loads a calibration code other than the factory value.

Top module: `osc_ctrl_unit`

## Requirements
- R1: After reset the control word reads 0xC0 (bit 7 enable = 1, bit 6 ready = 1), the calibration register reads the factory parameter CAL_RESET, and usb_clk_ok is 1.
- R2: Control bits 1:0 set the divide ratio: 2'b11 = 1, 2'b10 = 2, 2'b01 = 4, 2'b00 = 8 oscillator ticks per sys_clk_en pulse. Each pulse is one clock wide and comes one clock after the tick that ends a period.
- R3: Control bits 4:2 read as 000 whatever is written to them, and bit 6 ignores writes.
- R4: Writing 1 to control bit 5 suspends the oscillator. osc_run drops, ready reads 0 and sys_clk_en stays low. Writing 0 to bit 5 does not end suspend.
- R5: A supply_wake pulse ends suspend and clears bit 5. A usb_resume pulse does the same only while usb_xcvr_active is 1, and it is ignored otherwise.
- R6: Ready reads 0 while the oscillator is disabled (bit 7 = 0) or suspended. After a restart it returns to 1 once SETTLE_TICKS oscillator ticks have been counted.
- R7: Writing the calibration register (address 1) with a value other than CAL_RESET clears usb_clk_ok. It stays 0 until reset, even if CAL_RESET is written back. Writing CAL_RESET before any other value leaves usb_clk_ok at 1.
- R8: A new divide ratio takes effect only at the end of the current divided period, so the gap between the last pulse at the old ratio and the next pulse equals the old period.
- R9: A suspend write and a wake event in the same cycle leave the oscillator suspended. A wake event while not suspended has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the control word, 1 selects calibration |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| osc_tick | input | 1 | One pulse per oscillator period (modelled oscillator) |
| usb_resume | input | 1 | USB resume / non-idle bus event |
| usb_xcvr_active | input | 1 | USB transceiver enabled or suspended |
| supply_wake | input | 1 | Supply-detect interrupt event |
| osc_run | output | 1 | Run request to the analog oscillator |
| osc_cal | output | CAL_W | Calibration trim code to the oscillator |
| sys_clk_en | output | 1 | Divided system clock enable pulse |
| usb_clk_ok | output | 1 | Oscillator still qualifies as USB clock |

## Verification
A suspend write and a wake event can land on the same clock edge. The wake logic only acts on suspend that is already held, so the write must win. The bench makes them collide by raising reg_wr with bit 5 set and supply_wake in the same cycle. It then reads bit 5 back as 1 and sees no enable pulses. A later lone wake pulse must still clear suspend, which shows the collision did not leave the wake path stuck.

// File: rtl/osc_ctrl_pkg.sv
// Package: shared field positions and divide-select encoding for the
// oscillator control unit. Assumes an 8-bit control word.
package osc_ctrl_pkg;
    localparam int CTRL_W   = 8;
    localparam int BIT_EN   = 7;
    localparam int BIT_RDY  = 6;
    localparam int BIT_SUSP = 5;
    localparam int DIV_CW   = 3;

    typedef enum logic [1:0] {
        DIV_BY_8 = 2'b00,
        DIV_BY_4 = 2'b01,
        DIV_BY_2 = 2'b10,
        DIV_BY_1 = 2'b11
    } div_sel_e;

    // Last tick count of a divided period for each select value.
    function automatic logic [DIV_CW-1:0] div_last(input div_sel_e s);
        case (s)
            DIV_BY_8: div_last = 3'd7;
            DIV_BY_4: div_last = 3'd3;
            DIV_BY_2: div_last = 3'd1;
            default:  div_last = 3'd0;
        endcase
    endfunction
endpackage

// File: rtl/osc_ctrl_regs.sv
// Control and calibration register state. Holds enable, suspend, divide
// select and trim code, resolves wake events and tracks USB-clock
// eligibility. Assumes wake inputs are already synchronous to clk.
module osc_ctrl_regs
    import osc_ctrl_pkg::*;
#(
    parameter int              CAL_W     = 7,
    parameter logic [CAL_W-1:0] CAL_RESET = 7'h4C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic             wr_cal,
    input  logic [CTRL_W-1:0] wdata,
    input  logic             usb_resume,
    input  logic             usb_xcvr_active,
    input  logic             supply_wake,
    output logic             en_o,
    output logic             susp_o,
    output div_sel_e         div_o,
    output logic [CAL_W-1:0] cal_o,
    output logic             usb_ok_o
);
    logic             en_q, susp_q, usb_ok_q;
    div_sel_e         div_q;
    logic [CAL_W-1:0] cal_q;
    logic             wake;

    // Wake qualification: USB only counts with an active transceiver.
    always_comb wake = supply_wake | (usb_resume & usb_xcvr_active);

    // Control word update: a suspend write wins over a same-cycle wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b1;
            susp_q <= 1'b0;
            div_q  <= DIV_BY_8;
        end else begin
            if (wr_ctrl) begin
                en_q  <= wdata[BIT_EN];
                div_q <= div_sel_e'(wdata[1:0]);
            end
            if (wr_ctrl && wdata[BIT_SUSP])
                susp_q <= 1'b1;
            else if (susp_q && wake)
                susp_q <= 1'b0;
        end
    end

    // Calibration code and sticky USB-clock eligibility.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_q    <= CAL_RESET;
            usb_ok_q <= 1'b1;
        end else if (wr_cal) begin
            cal_q <= wdata[CAL_W-1:0];
            if (wdata[CAL_W-1:0] != CAL_RESET)
                usb_ok_q <= 1'b0;
        end
    end

    assign en_o     = en_q;
    assign susp_o   = susp_q;
    assign div_o    = div_q;
    assign cal_o    = cal_q;
    assign usb_ok_o = usb_ok_q;

    // R5
    susp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(susp_q) |-> $past(wake));
    // R4
    susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_q && !wake) |=> susp_q);
    // R7
    usb_ok_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !usb_ok_q |=> !usb_ok_q);
    // R9
    susp_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[BIT_SUSP]) |=> susp_q);
endmodule

// File: rtl/osc_settle.sv
// Settling timer: drops the ready flag whenever the oscillator is not
// running and raises it again after SETTLE_TICKS gated oscillator ticks.
// Assumes tick_i only pulses while run_i is high.
module osc_settle #(
    parameter int SETTLE_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    output logic ready_o
);
    localparam int CW = $clog2(SETTLE_TICKS + 1);
    logic [CW-1:0] cnt_q;
    logic          ready_q;

    // Count ticks after a restart until the settle limit is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ready_q <= 1'b1;
        end else if (!run_i) begin
            cnt_q   <= '0;
            ready_q <= 1'b0;
        end else if (!ready_q && tick_i) begin
            if (cnt_q == CW'(SETTLE_TICKS - 1)) begin
                cnt_q   <= '0;
                ready_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign ready_o = ready_q;

    // R6
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !ready_o);
    // R6
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(tick_i));
endmodule

// File: rtl/osc_clk_div.sv
// Tick divider: emits a one-cycle enable every 1, 2, 4 or 8 gated ticks.
// A new select is adopted only at a period boundary, so no short period
// occurs. Assumes tick_i is already gated by the run state.
module osc_clk_div
    import osc_ctrl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick_i,
    input  div_sel_e div_req_i,
    output logic     clk_en_o
);
    logic [DIV_CW-1:0] cnt_q;
    div_sel_e          div_act_q;
    logic              en_q;

    // Period counter with boundary-aligned adoption of the requested ratio.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            div_act_q <= DIV_BY_8;
            en_q      <= 1'b0;
        end else if (tick_i) begin
            if (cnt_q == div_last(div_act_q)) begin
                cnt_q     <= '0;
                div_act_q <= div_req_i;
                en_q      <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                en_q  <= 1'b0;
            end
        end else begin
            en_q <= 1'b0;
        end
    end

    assign clk_en_o = en_q;

    // R2
    en_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_o |-> $past(tick_i));
    // R8
    ratio_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_act_q != $past(div_act_q)) |-> clk_en_o);
endmodule

// File: rtl/osc_ctrl_unit.sv
// Top of the oscillator control unit: decodes the register port, gates
// oscillator ticks with the run state, and ties the register, settle
// and divider blocks together. Assumes all inputs are synchronous to clk.
module osc_ctrl_unit
    import osc_ctrl_pkg::*;
#(
    parameter int               CAL_W        = 7,
    parameter logic [CAL_W-1:0] CAL_RESET    = 7'h4C,
    parameter int               SETTLE_TICKS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             osc_tick,
    input  logic             usb_resume,
    input  logic             usb_xcvr_active,
    input  logic             supply_wake,
    output logic             osc_run,
    output logic [CAL_W-1:0] osc_cal,
    output logic             sys_clk_en,
    output logic             usb_clk_ok
);
    logic             en, susp, ready, run, tick_g;
    div_sel_e         div_sel;
    logic [CAL_W-1:0] cal;

    osc_ctrl_regs #(.CAL_W(CAL_W), .CAL_RESET(CAL_RESET)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_ctrl(reg_wr && !reg_addr), .wr_cal(reg_wr && reg_addr),
        .wdata(reg_wdata),
        .usb_resume(usb_resume), .usb_xcvr_active(usb_xcvr_active),
        .supply_wake(supply_wake),
        .en_o(en), .susp_o(susp), .div_o(div_sel), .cal_o(cal),
        .usb_ok_o(usb_clk_ok)
    );

    // Run state and gated oscillator ticks.
    always_comb begin
        run    = en & ~susp;
        tick_g = osc_tick & run;
    end

    osc_settle #(.SETTLE_TICKS(SETTLE_TICKS)) u_settle (
        .clk(clk), .rst_n(rst_n), .run_i(run), .tick_i(tick_g), .ready_o(ready)
    );

    osc_clk_div u_div (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_g), .div_req_i(div_sel),
        .clk_en_o(sys_clk_en)
    );

    // Read mux: unused control bits forced to zero, calibration zero-extended.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr) begin
            reg_rdata[CAL_W-1:0] = cal;
        end else begin
            reg_rdata[BIT_EN]   = en;
            reg_rdata[BIT_RDY]  = ready;
            reg_rdata[BIT_SUSP] = susp;
            reg_rdata[1:0]      = div_sel;
        end
    end

    assign osc_run = run;
    assign osc_cal = cal;

    // R4
    no_en_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_run |=> !sys_clk_en);
endmodule

// File: tb/osc_ctrl_unit_tb.sv
// Directed bench for the oscillator control unit; one task per scenario.
module osc_ctrl_unit_tb_top;
    localparam int CAL_W = 7;
    localparam logic [CAL_W-1:0] CAL_RST = 7'h4C;
    localparam int SETTLE = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic osc_tick = 1'b0, usb_resume = 1'b0, usb_xcvr_active = 1'b0, supply_wake = 1'b0;
    logic osc_run, sys_clk_en, usb_clk_ok;
    logic [CAL_W-1:0] osc_cal;
    int n_chk = 0, n_fail = 0, cyc = 0;

    osc_ctrl_unit #(.CAL_W(CAL_W), .CAL_RESET(CAL_RST), .SETTLE_TICKS(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .osc_tick(osc_tick),
        .usb_resume(usb_resume), .usb_xcvr_active(usb_xcvr_active),
        .supply_wake(supply_wake), .osc_run(osc_run), .osc_cal(osc_cal),
        .sys_clk_en(sys_clk_en), .usb_clk_ok(usb_clk_ok)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Oscillator model: one tick every second clock.
    initial forever begin
        @(negedge clk);
        osc_tick = ~osc_tick;
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    task automatic write_reg(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_reg(input logic a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic count_en(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sys_clk_en) c++;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        read_reg(1'b0, d);
        check(d == 8'hC0, "R1 ctrl reset", d, 8'hC0);
        read_reg(1'b1, d);
        check(d == {1'b0, CAL_RST}, "R1 cal reset", d, {1'b0, CAL_RST});
        check(usb_clk_ok == 1'b1, "R1 usb_clk_ok reset", usb_clk_ok, 1);
    endtask

    task automatic t_divide();
        logic [7:0] d;
        int c;
        for (int s = 0; s < 4; s++) begin
            write_reg(1'b0, 8'h80 | 8'(s) | 8'h5C);
            repeat (24) @(negedge clk);
            read_reg(1'b0, d);
            check(d == (8'hC0 | 8'(s)), "R3 unused bits and ready ignore writes", d, 8'hC0 | 8'(s));
            count_en(64, c);
            check(c == 64 / (2 * (8 >> s)), "R2 divide ratio pulse count", c, 64 / (2 * (8 >> s)));
        end
    endtask

    task automatic t_boundary();
        int t0, gap;
        write_reg(1'b0, 8'h80);
        repeat (24) @(negedge clk);
        while (!sys_clk_en) @(negedge clk);
        t0 = cyc;
        write_reg(1'b0, 8'h83);
        @(negedge clk);
        while (!sys_clk_en) @(negedge clk);
        gap = cyc - t0; t0 = cyc;
        check(gap == 16, "R8 old period kept to boundary", gap, 16);
        @(negedge clk);
        while (!sys_clk_en) @(negedge clk);
        gap = cyc - t0;
        check(gap == 2, "R8 new period after boundary", gap, 2);
    endtask

    task automatic t_suspend();
        logic [7:0] d;
        int c;
        write_reg(1'b0, 8'hA3);
        @(negedge clk);
        read_reg(1'b0, d);
        check(d == 8'hA3, "R4 suspended, ready low", d, 8'hA3);
        check(osc_run == 1'b0, "R4 osc_run low", osc_run, 0);
        count_en(20, c);
        check(c == 0, "R4 no enables while suspended", c, 0);
        write_reg(1'b0, 8'h83);
        read_reg(1'b0, d);
        check(d[5] == 1'b1, "R4 writing 0 keeps suspend", d[5], 1);
    endtask

    task automatic pulse_wake(input logic usb, input logic xcvr);
        @(negedge clk);
        usb_xcvr_active = xcvr;
        if (usb) usb_resume = 1'b1; else supply_wake = 1'b1;
        @(negedge clk);
        usb_resume = 1'b0; supply_wake = 1'b0;
    endtask

    task automatic t_wake_usb();
        logic [7:0] d;
        pulse_wake(1'b1, 1'b0);
        read_reg(1'b0, d);
        check(d[5] == 1'b1, "R5 usb resume ignored without transceiver", d[5], 1);
        pulse_wake(1'b1, 1'b1);
        read_reg(1'b0, d);
        check(d[5] == 1'b0, "R5 usb resume wakes", d[5], 0);
        repeat (8) @(negedge clk);
        read_reg(1'b0, d);
        check(d[6] == 1'b0, "R6 ready low while settling", d[6], 0);
        repeat (16) @(negedge clk);
        read_reg(1'b0, d);
        check(d[6] == 1'b1, "R6 ready after settle ticks", d[6], 1);
        usb_xcvr_active = 1'b0;
    endtask

    task automatic t_wake_supply();
        logic [7:0] d;
        write_reg(1'b0, 8'hA3);
        pulse_wake(1'b0, 1'b0);
        read_reg(1'b0, d);
        check(d[5] == 1'b0, "R5 supply wake clears suspend", d[5], 0);
        check(osc_run == 1'b1, "R5 osc_run after supply wake", osc_run, 1);
    endtask

    task automatic t_disable();
        logic [7:0] d;
        write_reg(1'b0, 8'h03);
        @(negedge clk);
        read_reg(1'b0, d);
        check(d == 8'h03, "R6 disabled, ready low", d, 8'h03);
        write_reg(1'b0, 8'h83);
        repeat (24) @(negedge clk);
        read_reg(1'b0, d);
        check(d == 8'hC3, "R6 ready back after enable", d, 8'hC3);
    endtask

    task automatic t_collision();
        logic [7:0] d;
        int c;
        pulse_wake(1'b0, 1'b0);
        read_reg(1'b0, d);
        check(d[5] == 1'b0, "R9 wake while running has no effect", d[5], 0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 8'hA3; supply_wake = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; supply_wake = 1'b0;
        read_reg(1'b0, d);
        check(d[5] == 1'b1, "R9 suspend write wins over wake", d[5], 1);
        count_en(12, c);
        check(c == 0, "R9 no enables after collision", c, 0);
        pulse_wake(1'b0, 1'b0);
        read_reg(1'b0, d);
        check(d[5] == 1'b0, "R9 later wake still clears", d[5], 0);
    endtask

    task automatic t_cal();
        logic [7:0] d;
        write_reg(1'b1, {1'b0, CAL_RST});
        check(usb_clk_ok == 1'b1, "R7 factory value keeps eligibility", usb_clk_ok, 1);
        write_reg(1'b1, 8'h21);
        read_reg(1'b1, d);
        check(d == 8'h21 && osc_cal == 7'h21, "R7 cal readback", d, 8'h21);
        check(usb_clk_ok == 1'b0, "R7 changed cal clears eligibility", usb_clk_ok, 0);
        write_reg(1'b1, {1'b0, CAL_RST});
        check(usb_clk_ok == 1'b0, "R7 eligibility sticky", usb_clk_ok, 0);
        do_reset();
        read_reg(1'b1, d);
        check(d == {1'b0, CAL_RST}, "R1 cal restored by reset", d, {1'b0, CAL_RST});
        check(usb_clk_ok == 1'b1, "R7 reset restores eligibility", usb_clk_ok, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        t_reset();
        t_divide();
        t_boundary();
        t_suspend();
        t_wake_usb();
        t_wake_supply();
        t_disable();
        t_collision();
        t_cal();
        finish_run();
    end
endmodule